// File: doc/BRIEF.md
# Framed serial sample streamer

The streamer turns four result words into one serial burst on a single data line, once per compute pass. A one-cycle start pulse, issued in the sync state of the conversion frame, latches all four 32-bit words and their four flag bits. The block then sends each word in its own slot. A slot opens with the word's flag bit, follows with the 32 data bits in least-significant-first order, and closes with two quiet cycles. A bit-valid strobe marks every cycle that carries a flag or data bit, so a receiver can sample the line without counting cycles.

A burst always lasts 140 cycles of the fast clock. This is short enough to finish before the next compute pass begins. A busy output covers the whole burst. A start pulse seen while busy has no effect.

Top module: `sample_streamer`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and on the first cycle after it, `busy_o`, `bit_vld_o` and `ser_o` are all low.
- R2: An accepted burst holds four slots of 35 cycles each, in word order 0 to 3, where word k is `word_i[32k+31:32k]`. Cycle 0 of slot k drives flag bit `flag_i[k]` with the strobe high.
- R3: Cycles 1 to 32 of a slot drive data bits 0 to 31 of that word in that order, with the strobe high. Bit 31, the sign bit, is last.
- R4: Cycles 33 and 34 of every slot hold `ser_o` low and `bit_vld_o` low.
- R5: `busy_o` rises in the cycle after an accepted start and stays high for exactly 140 cycles.
- R6: The strobe is high on exactly 132 cycles per burst and never while `busy_o` is low.
- R7: Words and flags are sampled only at the accepting clock edge. Changes to `word_i` or `flag_i` during a burst do not alter the bits sent.
- R8: A start pulse sampled while `busy_o` is high is ignored, including one on the last busy cycle. The burst in progress runs on unchanged and no new burst follows.
- R9: A start sampled on the first idle cycle after a burst is accepted, so a held start produces bursts separated by one idle cycle.
- R10: `ser_o` is low on every cycle where `bit_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request; accepted only while idle |
| word_i | input | 128 | Four 32-bit words, word k in bits 32k+31:32k |
| flag_i | input | 4 | Flag bit k precedes word k |
| ser_o | output | 1 | Serial data line |
| bit_vld_o | output | 1 | High on each flag or data bit cycle |
| busy_o | output | 1 | High for the whole 140-cycle burst |

## Verification
The bench targets several boundaries. The first is the seam between a slot's last data bit and its two quiet cycles; an off-by-one there would send bit 31 late or drop it, or leave the strobe high in the gap. It also rewrites the inputs in the middle of a burst, which exposes a design that reads the live inputs and not the latched copy. It fires start on the final busy cycle, where a design with a loose acceptance condition would restart and stretch busy. It holds start high so that the single idle cycle between back-to-back bursts is checked; a design that idles too long or too briefly fails there.

// File: rtl/ss_pkg.sv
package ss_pkg;

  // cycles in one word slot: flag + data + quiet gap
  function automatic int unsigned slot_len(input int unsigned word_w, input int unsigned gap);
    return 1 + word_w + gap;
  endfunction

  // slot position carries a data bit
  function automatic bit pos_is_data(input int unsigned pos, input int unsigned word_w);
    return (pos >= 1) && (pos <= word_w);
  endfunction

  // slot position carries the flag bit
  function automatic bit pos_is_flag(input int unsigned pos);
    return pos == 0;
  endfunction

  // total burst length
  function automatic int unsigned burst_len(input int unsigned words, input int unsigned word_w,
                                            input int unsigned gap);
    return words * slot_len(word_w, gap);
  endfunction

endpackage

// File: rtl/ss_seq.sv
module ss_seq #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned SLOT  = 35,
  parameter int unsigned PW    = 6,
  parameter int unsigned WW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy,
  output logic          accept,
  output logic          last,
  output logic [PW-1:0] pos,
  output logic [WW-1:0] wrd
);
  localparam logic [PW-1:0] POS_LAST = PW'(SLOT - 1);
  localparam logic [WW-1:0] WRD_LAST = WW'(WORDS - 1);

  logic          busy_q;
  logic [PW-1:0] pos_q;
  logic [WW-1:0] wrd_q;
  logic          slot_end;

  assign accept   = start_i && !busy_q;
  assign slot_end = busy_q && (pos_q == POS_LAST);
  assign last     = slot_end && (wrd_q == WRD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      wrd_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
      wrd_q  <= '0;
    end else if (busy_q) begin
      if (slot_end) begin
        pos_q <= '0;
        if (last) busy_q <= 1'b0;
        else      wrd_q  <= wrd_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign pos  = pos_q;
  assign wrd  = wrd_q;
endmodule

// File: rtl/ss_store.sv
module ss_store #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WW     = 2,
  parameter int unsigned BW     = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [WORDS*WORD_W-1:0] word_i,
  input  logic [WORDS-1:0]        flag_i,
  input  logic [WW-1:0]           sel,
  input  logic [BW-1:0]           bit_idx,
  output logic                    flag_bit,
  output logic                    data_bit
);
  logic [WORD_W-1:0] word_q [WORDS];
  logic [WORDS-1:0]  flag_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q[g] <= '0;
      else if (load) word_q[g] <= word_i[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= '0;
    else if (load) flag_q <= flag_i;
  end

  assign flag_bit = flag_q[sel];
  assign data_bit = word_q[sel][bit_idx];
endmodule

// File: rtl/sample_streamer.sv
module sample_streamer #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned GAP    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [WORDS*WORD_W-1:0] word_i,
  input  logic [WORDS-1:0]        flag_i,
  output logic                    ser_o,
  output logic                    bit_vld_o,
  output logic                    busy_o
);
  localparam int unsigned SLOT = ss_pkg::slot_len(WORD_W, GAP);
  localparam int unsigned PW   = $clog2(SLOT);
  localparam int unsigned WW   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned BW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic          busy_w, accept_w, last_w;
  logic [PW-1:0] pos_w;
  logic [WW-1:0] wrd_w;
  logic [BW-1:0] bit_idx_w;
  logic          flag_bit_w, data_bit_w;
  logic          is_flag_w, is_data_w;

  ss_seq #(.WORDS(WORDS), .SLOT(SLOT), .PW(PW), .WW(WW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy(busy_w), .accept(accept_w), .last(last_w),
    .pos(pos_w), .wrd(wrd_w)
  );

  assign bit_idx_w = BW'(pos_w - 1'b1);

  ss_store #(.WORDS(WORDS), .WORD_W(WORD_W), .WW(WW), .BW(BW)) u_store (
    .clk(clk), .rst_n(rst_n), .load(accept_w),
    .word_i(word_i), .flag_i(flag_i),
    .sel(wrd_w), .bit_idx(bit_idx_w),
    .flag_bit(flag_bit_w), .data_bit(data_bit_w)
  );

  assign is_flag_w = busy_w && ss_pkg::pos_is_flag(32'(pos_w));
  assign is_data_w = busy_w && ss_pkg::pos_is_data(32'(pos_w), WORD_W);

  assign bit_vld_o = is_flag_w || is_data_w;
  assign ser_o     = is_flag_w ? flag_bit_w : (is_data_w ? data_bit_w : 1'b0);
  assign busy_o    = busy_w;
endmodule

// File: rtl/ss_chk.sv
module ss_chk #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned GAP    = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic bit_vld_o,
  input logic ser_o,
  input logic accept_w,
  input logic last_w
);
  localparam int unsigned TOTAL = ss_pkg::burst_len(WORDS, WORD_W, GAP);
  localparam int unsigned BITS  = WORDS * (WORD_W + 1);

  int unsigned run_cnt, vld_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= 0;
      vld_cnt <= 0;
    end else if (!busy_o) begin
      run_cnt <= 0;
      vld_cnt <= 0;
    end else begin
      run_cnt <= run_cnt + 1;
      vld_cnt <= vld_cnt + (bit_vld_o ? 1 : 0);
    end
  end

  // R5
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy_o);
  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_cnt == TOTAL);
  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_cnt < TOTAL);
  // R6
  vld_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> vld_cnt == BITS);
  // R6
  vld_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> busy_o);
  // R10
  ser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld_o |-> !ser_o);
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o && !last_w |=> busy_o && run_cnt != 0);
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) && start_i |=> busy_o);
endmodule

bind sample_streamer ss_chk #(.WORDS(WORDS), .WORD_W(WORD_W), .GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .bit_vld_o(bit_vld_o), .ser_o(ser_o), .accept_w(accept_w), .last_w(last_w)
);

// File: tb/sample_streamer_bench.sv
module sample_streamer_bench;
  localparam int WORDS = 4, WORD_W = 32, GAP = 2;
  localparam int SLOT = 1 + WORD_W + GAP;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst_n, start_i;
  logic [WORDS*WORD_W-1:0] word_i;
  logic [WORDS-1:0]        flag_i;
  logic                    ser_o, bit_vld_o, busy_o;

  sample_streamer #(.WORDS(WORDS), .WORD_W(WORD_W), .GAP(GAP)) u_sample_streamer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i), .flag_i(flag_i),
    .ser_o(ser_o), .bit_vld_o(bit_vld_o), .busy_o(busy_o)
  );

  int    errors = 0, checks = 0;
  bit    done = 1'b0;
  string req_tag = "R1";
  logic [1:0] q[$];   // {valid, data} per future cycle

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req_tag, what, act, exp, $time);
    end
  endtask

  // reference model: a list of the cycles still to send
  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else if (q.size() > 0) q.delete(0);
    else if (start_i) begin
      for (int w = 0; w < WORDS; w++)
        for (int p = 0; p < SLOT; p++) begin
          if (p == 0)            q.push_back({1'b1, flag_i[w]});
          else if (p <= WORD_W)  q.push_back({1'b1, word_i[w*WORD_W + p - 1]});
          else                   q.push_back(2'b00);
        end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy_o, q.size() > 0, "busy R5");
      chk(bit_vld_o, (q.size() > 0) ? q[0][1] : 1'b0, "strobe R2/R6/R4");
      chk(ser_o, (q.size() > 0) ? q[0][0] : 1'b0, "data R3/R4/R10");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; word_i = '0; flag_i = '0;
    cyc(3);
    req_tag = "R1";
    chk(busy_o, 1'b0, "reset busy");
    chk(bit_vld_o, 1'b0, "reset strobe");
    chk(ser_o, 1'b0, "reset data");
    rst_n = 1'b1;
    cyc(2);

    // R2 R3 R4: mixed patterns; R7: inputs rewritten mid-burst
    req_tag = "R2_R3_R7";
    word_i = {32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h8000_0001};
    flag_i = 4'b1010;
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    cyc(50);
    word_i = {32'h1234_5678, 32'h0F0F_0F0F, 32'hDEAD_BEEF, 32'h7FFF_FFFE};
    flag_i = 4'b0101;
    cyc(100);

    // R8: starts during busy, one on the final busy cycle
    req_tag = "R8";
    word_i = {32'h0000_8000, 32'h4000_0000, 32'h0000_0002, 32'h8000_0000};
    flag_i = 4'b0110;
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    cyc(10);  start_i = 1'b1; cyc(1); start_i = 1'b0;
    cyc(60);  start_i = 1'b1; cyc(3); start_i = 1'b0;
    cyc(65);  start_i = 1'b1; cyc(1); start_i = 1'b0;   // lands on cycle 139
    cyc(20);

    // R9: start held high, back-to-back bursts
    req_tag = "R9";
    word_i = {32'hC000_0003, 32'h5555_AAAA, 32'h0000_FFFF, 32'hFFFF_0000};
    flag_i = 4'b1111;
    start_i = 1'b1; cyc(300); start_i = 1'b0;
    cyc(150);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule